// File: doc/BRIEF.md
# Round-Robin Ping-Pong Pixel Bus Interface

This block sits between a pixel filter core and a shared memory bus whose beats are eight pixels wide. It has several read streams, by default two (source image and guidance image), and one write stream for results. Each stream owns a buffer of two banks, and each bank holds one bus beat of pixels. The core works on one bank while the bus fills or empties the other. On the core side every stream is a pixel-wide valid/ready port. On the bus side, a controller picks one stream at a time in rotating order and issues a transaction. The address phase of that transaction can overlap the data phases of earlier ones.

A row begins with a one-cycle `row_start` pulse, which loads a base byte address for every stream. Each read stream then fetches a fixed number of consecutive beats from its base. Nothing is cached: every beat is fetched fresh from memory. The write stream stores each group of eight result pixels at consecutive beat addresses from its own base. The core marks the last result pixel of a row, and the partly filled bank is then flushed with only its valid lanes enabled. Read data returns a fixed number of cycles after the address phase is accepted. A tag that travels alongside the transaction sends the data to the stream and bank that asked for it.

Top module: `pixbus_rr_ctrl`

## Requirements
- R1: In reset and directly after it, `bus_req` is 0, `bus_wvalid` is 0, every `rd_valid` bit is 0 and `wr_ready` is 1.
- R2: Once `bus_req` is high, it stays high with `bus_addr` and `bus_we` unchanged until a cycle in which `bus_ack` is high. The address phase is accepted in that cycle.
- R3: A read accepted in cycle c takes its data from `bus_rdata` in cycle c+LAT. The pixel at bit offset 8*j of the beat reaches the core as the j-th pixel of that beat. The k-th pixel of read stream s in a row is the memory byte at address base_s + k. While `rd_valid` is high and `rd_ready` is low, the pixel is held.
- R4: A read stream has at most two beats requested or buffered at a time. It issues exactly LAT-independent ROW_TILES read beats per row, at addresses base_s + 8*t for t = 0, 1, and so on. No read is issued before the first `row_start` after reset.
- R5: Arbitration order is read stream 0, read stream 1, and so on, then the write stream, and it wraps around. After a grant, the search starts at the next requester. Requesters that are not asking are skipped in the same cycle. The same requester is granted twice in a row only when it is the only one asking. Right after reset the search starts at read stream 0.
- R6: A write accepted in cycle c drives `bus_wvalid`=1 together with `bus_wdata` and `bus_wstrb` in cycle c+LAT. The t-th write beat of a row goes to out_base + 8*t. Within the beat, the j-th pixel pushed into that bank is at bit offset 8*j, and a full bank has `bus_wstrb` = 8'hFF.
- R7: A pixel pushed with `wr_last`=1 closes its bank. If that bank holds n pixels, where n < 8, the beat carries `bus_wstrb` = (1<<n)-1, so its lanes are enabled from lane 0 upward.
- R8: The write stream asks for the bus only when a bank has been closed.
- R9: `wr_ready` goes low while both write banks are closed and waiting for the bus. Pushes are then held off, and no pixel is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_start | input | 1 | Pulse that starts a row and loads the base addresses |
| rd_base | input | NUM_RD*ADDR_W | Row base byte address of each read stream, stream s in slice s |
| out_base | input | ADDR_W | Row base byte address of the write stream |
| rd_data | output | NUM_RD*PIX_W | Pixel offered to the core by each read stream |
| rd_valid | output | NUM_RD | Pixel of each read stream is valid |
| rd_ready | input | NUM_RD | Core takes the pixel of each read stream |
| wr_data | input | PIX_W | Result pixel from the core |
| wr_valid | input | 1 | Result pixel is valid |
| wr_last | input | 1 | Result pixel is the last one of the row |
| wr_ready | output | 1 | Write buffer accepts a pixel |
| bus_req | output | 1 | Address phase pending |
| bus_we | output | 1 | Pending access is a write |
| bus_addr | output | ADDR_W | Byte address of the pending access |
| bus_ack | input | 1 | Memory accepts the pending address phase |
| bus_rdata | input | BANK_PIX*PIX_W | Read beat, sampled LAT cycles after acceptance |
| bus_wvalid | output | 1 | Write data phase in this cycle |
| bus_wdata | output | BANK_PIX*PIX_W | Write beat |
| bus_wstrb | output | BANK_PIX | Lane enables of the write beat |

## Verification
The assertions assume two things about the environment. The memory supplies read data exactly LAT cycles after it raises `bus_ack`, and `row_start` arrives only after the previous row has drained. The bench memory model keeps to both. It queues each accepted address phase with its due cycle, and it drives `bus_rdata` in that cycle only. The bench starts a new row only once every read pixel has been consumed and every write beat has been checked. Within those limits, `bus_ack`, `rd_ready` and `wr_valid` are drawn from a fixed-seed random source. Directed windows hold the bus fully open and fully stalled to expose the grant order and the write back-pressure.

// File: rtl/pixbus_pkg.sv
package pixbus_pkg;

  typedef enum logic [1:0] {
    BK_EMPTY = 2'd0,
    BK_PEND  = 2'd1,
    BK_FULL  = 2'd2
  } bank_st_e;

  // byte address of beat k of a row
  function automatic logic [63:0] beat_addr(input logic [63:0] base,
                                            input int unsigned k,
                                            input int unsigned bytes);
    return base + 64'(k) * 64'(bytes);
  endfunction

  // lane enables for a bank holding cnt pixels, lane 0 upward
  function automatic logic [63:0] lane_mask(input int unsigned cnt);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (i < int'(cnt));
    return m;
  endfunction

  // wrap an index that is below 2*n into 0..n-1
  function automatic int unsigned rr_wrap(input int unsigned v, input int unsigned n);
    return (v >= n) ? v - n : v;
  endfunction

endpackage

// File: rtl/pixbus_rr_arb.sv
module pixbus_rr_arb #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gidx
);
  import pixbus_pkg::*;

  logic [IW-1:0] ptr;

  // scan from the far end so the closest requester after ptr wins
  always_comb begin
    gnt  = '0;
    gidx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[rr_wrap(32'(ptr) + 32'(k), 32'(N))]) begin
        gnt  = '0;
        gnt[rr_wrap(32'(ptr) + 32'(k), 32'(N))] = 1'b1;
        gidx = IW'(rr_wrap(32'(ptr) + 32'(k), 32'(N)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (advance && (|gnt)) ptr <= IW'(rr_wrap(32'(gidx) + 32'd1, 32'(N)));
  end

endmodule

// File: rtl/pixbus_rd_fifo.sv
module pixbus_rd_fifo #(
  parameter int PIX_W     = 8,
  parameter int BANK_PIX  = 8,
  parameter int ROW_TILES = 12,
  parameter int ADDR_W    = 32,
  localparam int BUS_W    = PIX_W * BANK_PIX,
  localparam int IDX_W    = $clog2(BANK_PIX),
  localparam int CNT_W    = $clog2(ROW_TILES + 1),
  localparam int BEAT_B   = BUS_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_start,
  input  logic [ADDR_W-1:0] base_in,
  output logic              req,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_bank,
  input  logic              grant,
  input  logic              fill_vld,
  input  logic              fill_bank,
  input  logic [BUS_W-1:0]  fill_data,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_valid,
  input  logic              pix_ready
);
  import pixbus_pkg::*;

  bank_st_e          st [2];
  logic [BUS_W-1:0]  mem [2];
  logic              fill_ptr, rd_ptr;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  issued;
  logic [ADDR_W-1:0] base;
  logic              pop;

  assign req       = (st[fill_ptr] == BK_EMPTY) && (issued < CNT_W'(ROW_TILES));
  assign req_bank  = fill_ptr;
  assign req_addr  = ADDR_W'(beat_addr(64'(base), 32'(issued), 32'(BEAT_B)));
  assign pix_valid = (st[rd_ptr] == BK_FULL);
  assign pix_data  = mem[rd_ptr][idx*PIX_W +: PIX_W];
  assign pop       = pix_valid && pix_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st[0]    <= BK_EMPTY;
      st[1]    <= BK_EMPTY;
      mem[0]   <= '0;
      mem[1]   <= '0;
      fill_ptr <= 1'b0;
      rd_ptr   <= 1'b0;
      idx      <= '0;
      issued   <= CNT_W'(ROW_TILES);
      base     <= '0;
    end else begin
      if (row_start) begin
        issued <= '0;
        base   <= base_in;
      end else if (grant) begin
        issued <= issued + CNT_W'(1);
      end
      if (grant) begin
        st[fill_ptr] <= BK_PEND;
        fill_ptr     <= ~fill_ptr;
      end
      if (fill_vld) begin
        st[fill_bank]  <= BK_FULL;
        mem[fill_bank] <= fill_data;
      end
      if (pop) begin
        if (idx == IDX_W'(BANK_PIX - 1)) begin
          st[rd_ptr] <= BK_EMPTY;
          rd_ptr     <= ~rd_ptr;
          idx        <= '0;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pixbus_wr_fifo.sv
module pixbus_wr_fifo #(
  parameter int PIX_W     = 8,
  parameter int BANK_PIX  = 8,
  parameter int ROW_TILES = 12,
  parameter int ADDR_W    = 32,
  localparam int BUS_W    = PIX_W * BANK_PIX,
  localparam int IDX_W    = $clog2(BANK_PIX),
  localparam int CNT_W    = $clog2(ROW_TILES + 1),
  localparam int BEAT_B   = BUS_W / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                row_start,
  input  logic [ADDR_W-1:0]   base_in,
  input  logic [PIX_W-1:0]    pix_data,
  input  logic                pix_valid,
  input  logic                pix_last,
  output logic                pix_ready,
  output logic                req,
  output logic [ADDR_W-1:0]   req_addr,
  output logic                req_bank,
  input  logic                grant,
  input  logic                drain_vld,
  input  logic                drain_bank,
  output logic [BUS_W-1:0]    out_data,
  output logic [BANK_PIX-1:0] out_strb
);
  import pixbus_pkg::*;

  bank_st_e          st  [2];
  logic [BUS_W-1:0]  mem [2];
  logic [IDX_W:0]    cnt [2];
  logic              wr_ptr, drain_ptr;
  logic [IDX_W-1:0]  widx;
  logic [CNT_W-1:0]  beats;
  logic [ADDR_W-1:0] base;
  logic              push, close;

  assign pix_ready = (st[wr_ptr] == BK_EMPTY);
  assign push      = pix_valid && pix_ready;
  assign close     = push && (pix_last || (widx == IDX_W'(BANK_PIX - 1)));
  assign req       = (st[drain_ptr] == BK_FULL);
  assign req_bank  = drain_ptr;
  assign req_addr  = ADDR_W'(beat_addr(64'(base), 32'(beats), 32'(BEAT_B)));
  assign out_data  = mem[drain_bank];
  assign out_strb  = BANK_PIX'(lane_mask(32'(cnt[drain_bank])));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st[0]     <= BK_EMPTY;
      st[1]     <= BK_EMPTY;
      mem[0]    <= '0;
      mem[1]    <= '0;
      cnt[0]    <= '0;
      cnt[1]    <= '0;
      wr_ptr    <= 1'b0;
      drain_ptr <= 1'b0;
      widx      <= '0;
      beats     <= '0;
      base      <= '0;
    end else begin
      if (row_start) begin
        beats <= '0;
        base  <= base_in;
      end else if (grant) begin
        beats <= beats + CNT_W'(1);
      end
      if (push) mem[wr_ptr][widx*PIX_W +: PIX_W] <= pix_data;
      if (close) begin
        st[wr_ptr]  <= BK_FULL;
        cnt[wr_ptr] <= {1'b0, widx} + (IDX_W+1)'(1);
        wr_ptr      <= ~wr_ptr;
        widx        <= '0;
      end else if (push) begin
        widx <= widx + IDX_W'(1);
      end
      if (grant) begin
        st[drain_ptr] <= BK_PEND;
        drain_ptr     <= ~drain_ptr;
      end
      if (drain_vld) st[drain_bank] <= BK_EMPTY;
    end
  end

endmodule

// File: rtl/pixbus_rr_ctrl.sv
module pixbus_rr_ctrl #(
  parameter int NUM_RD    = 2,
  parameter int PIX_W     = 8,
  parameter int BANK_PIX  = 8,
  parameter int ROW_TILES = 12,
  parameter int ADDR_W    = 32,
  parameter int LAT       = 3,
  localparam int BUS_W    = PIX_W * BANK_PIX,
  localparam int NRQ      = NUM_RD + 1,
  localparam int IDW      = $clog2(NRQ)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     row_start,
  input  logic [NUM_RD*ADDR_W-1:0] rd_base,
  input  logic [ADDR_W-1:0]        out_base,
  output logic [NUM_RD*PIX_W-1:0]  rd_data,
  output logic [NUM_RD-1:0]        rd_valid,
  input  logic [NUM_RD-1:0]        rd_ready,
  input  logic [PIX_W-1:0]         wr_data,
  input  logic                     wr_valid,
  input  logic                     wr_last,
  output logic                     wr_ready,
  output logic                     bus_req,
  output logic                     bus_we,
  output logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_ack,
  input  logic [BUS_W-1:0]         bus_rdata,
  output logic                     bus_wvalid,
  output logic [BUS_W-1:0]         bus_wdata,
  output logic [BANK_PIX-1:0]      bus_wstrb
);

  // named internal events, also used by the checker
  logic [NRQ-1:0]    arb_req, arb_gnt, fifo_grant;
  logic [IDW-1:0]    gidx;
  logic [ADDR_W-1:0] req_addr [NRQ];
  logic [NRQ-1:0]    req_bank;
  logic              slot_free, accept;
  logic [IDW-1:0]    a_id;
  logic              a_bank;

  logic              t_vld  [LAT];
  logic              t_we   [LAT];
  logic [IDW-1:0]    t_id   [LAT];
  logic              t_bank [LAT];
  logic              dp_vld, dp_we, dp_bank;
  logic [IDW-1:0]    dp_id;

  assign slot_free  = !bus_req || bus_ack;
  assign accept     = bus_req && bus_ack;
  assign fifo_grant = arb_gnt & {NRQ{slot_free}};
  assign dp_vld     = t_vld[LAT-1];
  assign dp_we      = t_we[LAT-1];
  assign dp_id      = t_id[LAT-1];
  assign dp_bank    = t_bank[LAT-1];
  assign bus_wvalid = dp_vld && dp_we;

  pixbus_rr_arb #(.N(NRQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(arb_req), .advance(slot_free),
    .gnt(arb_gnt), .gidx(gidx)
  );

  for (genvar i = 0; i < NUM_RD; i++) begin : g_rd
    localparam logic [IDW-1:0] MY_ID = IDW'(i);
    logic fill_hit;
    assign fill_hit = dp_vld && !dp_we && (dp_id == MY_ID);
    pixbus_rd_fifo #(.PIX_W(PIX_W), .BANK_PIX(BANK_PIX), .ROW_TILES(ROW_TILES),
                     .ADDR_W(ADDR_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .row_start(row_start),
      .base_in(rd_base[i*ADDR_W +: ADDR_W]),
      .req(arb_req[i]), .req_addr(req_addr[i]), .req_bank(req_bank[i]),
      .grant(fifo_grant[i]), .fill_vld(fill_hit), .fill_bank(dp_bank),
      .fill_data(bus_rdata),
      .pix_data(rd_data[i*PIX_W +: PIX_W]), .pix_valid(rd_valid[i]),
      .pix_ready(rd_ready[i])
    );
  end

  pixbus_wr_fifo #(.PIX_W(PIX_W), .BANK_PIX(BANK_PIX), .ROW_TILES(ROW_TILES),
                   .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .base_in(out_base),
    .pix_data(wr_data), .pix_valid(wr_valid), .pix_last(wr_last),
    .pix_ready(wr_ready),
    .req(arb_req[NUM_RD]), .req_addr(req_addr[NUM_RD]), .req_bank(req_bank[NUM_RD]),
    .grant(fifo_grant[NUM_RD]), .drain_vld(bus_wvalid), .drain_bank(dp_bank),
    .out_data(bus_wdata), .out_strb(bus_wstrb)
  );

  // address phase register: reloaded whenever the slot frees up
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_req  <= 1'b0;
      bus_we   <= 1'b0;
      bus_addr <= '0;
      a_id     <= '0;
      a_bank   <= 1'b0;
    end else if (slot_free) begin
      bus_req <= |arb_gnt;
      if (|arb_gnt) begin
        bus_addr <= req_addr[gidx];
        bus_we   <= (gidx == IDW'(NUM_RD));
        a_id     <= gidx;
        a_bank   <= req_bank[gidx];
      end
    end
  end

  // tag pipeline: accepted access reaches the data phase LAT cycles later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) begin
        t_vld[k]  <= 1'b0;
        t_we[k]   <= 1'b0;
        t_id[k]   <= '0;
        t_bank[k] <= 1'b0;
      end
    end else begin
      t_vld[0]  <= accept;
      t_we[0]   <= bus_we;
      t_id[0]   <= a_id;
      t_bank[0] <= a_bank;
      for (int k = 1; k < LAT; k++) begin
        t_vld[k]  <= t_vld[k-1];
        t_we[k]   <= t_we[k-1];
        t_id[k]   <= t_id[k-1];
        t_bank[k] <= t_bank[k-1];
      end
    end
  end

endmodule

// File: rtl/pixbus_rr_chk.sv
module pixbus_rr_chk #(
  parameter int NRQ      = 3,
  parameter int NUM_RD   = 2,
  parameter int PIX_W    = 8,
  parameter int BANK_PIX = 8,
  parameter int ADDR_W   = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_req,
  input logic                    bus_ack,
  input logic                    bus_we,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_wvalid,
  input logic [BANK_PIX-1:0]     bus_wstrb,
  input logic [NRQ-1:0]          arb_req,
  input logic [NRQ-1:0]          arb_gnt,
  input logic                    slot_free,
  input logic [NUM_RD-1:0]       rd_valid,
  input logic [NUM_RD-1:0]       rd_ready,
  input logic [NUM_RD*PIX_W-1:0] rd_data
);

  logic [NRQ-1:0] last_gnt;
  logic           fire;
  assign fire = slot_free && (|arb_gnt);

  always_ff @(posedge clk) begin
    if (!rst_n) last_gnt <= '0;
    else if (fire) last_gnt <= arb_gnt;
  end

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  assert_gnt_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_gnt));

  assert_rr_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (arb_gnt == last_gnt)) |-> (arb_req == last_gnt));

  assert_strb_contig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wvalid |-> ((bus_wstrb != '0) &&
                    ((BANK_PIX'(bus_wstrb + BANK_PIX'(1)) & bus_wstrb) == '0)));

  for (genvar s = 0; s < NUM_RD; s++) begin : g_hold
    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[s] && !rd_ready[s]) |=>
        (rd_valid[s] && $stable(rd_data[s*PIX_W +: PIX_W])));
  end

endmodule

bind pixbus_rr_ctrl pixbus_rr_chk #(
  .NRQ(NRQ), .NUM_RD(NUM_RD), .PIX_W(PIX_W), .BANK_PIX(BANK_PIX), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wvalid(bus_wvalid), .bus_wstrb(bus_wstrb),
  .arb_req(arb_req), .arb_gnt(arb_gnt), .slot_free(slot_free),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/pixbus_rr_ctrl_test.sv
module pixbus_rr_ctrl_test;
  localparam int NUM_RD = 2;
  localparam int LAT    = 3;
  localparam int TILES  = 12;
  localparam int RPIX   = TILES * 8;
  localparam int WTOT   = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        row_start = 1'b0;
  logic [63:0] rd_base = '0;
  logic [31:0] out_base = '0;
  logic [15:0] rd_data;
  logic [1:0]  rd_valid;
  logic [1:0]  rd_ready = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0, wr_last = 1'b0, wr_ready;
  logic        bus_req, bus_we, bus_wvalid;
  logic [31:0] bus_addr;
  logic        bus_ack = 1'b0;
  logic [63:0] bus_rdata = '0, bus_wdata;
  logic [7:0]  bus_wstrb;

  pixbus_rr_ctrl #(.NUM_RD(NUM_RD), .ROW_TILES(TILES), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .rd_base(rd_base),
    .out_base(out_base), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_last(wr_last), .wr_ready(wr_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .bus_wvalid(bus_wvalid), .bus_wdata(bus_wdata),
    .bus_wstrb(bus_wstrb)
  );

  always #5 clk = ~clk;

  int total = 0, fails = 0;
  bit done = 0;
  int ack_mode = 0, rdy_mode = 0, wr_mode = 0, row = 0;
  int rcnt [2];
  int wcnt = 0, wbeats = 0, nrd = 0, acc_n = 0, ncyc = 0;
  logic [31:0] acc_log [8];
  logic [31:0] rb [2];
  int          q_due [$];
  logic [31:0] q_addr [$];
  logic        q_we [$];

  function automatic logic [7:0] mb(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd13 + (a >> 8) * 32'd7;
    return t[7:0];
  endfunction

  function automatic logic [7:0] wpix(input int i, input int r);
    return 8'(i * 37 + r * 11 + 1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and core-side agents, all acting at the falling edge
  initial begin
    rcnt[0] = 0; rcnt[1] = 0;
    void'($urandom(32'd1234));
    forever begin
      @(negedge clk);
      ncyc++;
      if (q_due.size() > 0 && q_due[0] == ncyc) begin
        logic [31:0] a;
        logic        we;
        a = q_addr.pop_front(); we = q_we.pop_front(); void'(q_due.pop_front());
        if (we) begin
          int k, n;
          logic [7:0] es;
          k = int'((a - out_base) >> 3);
          n = (WTOT - 8 * k < 8) ? WTOT - 8 * k : 8;
          es = 8'((16'd1 << n) - 16'd1);
          chk("R6 wvalid in data phase", 64'(bus_wvalid), 64'd1);
          chk("R7 write lane enables", 64'(bus_wstrb), 64'(es));
          for (int j = 0; j < n; j++)
            chk("R6 write pixel", 64'(bus_wdata[8*j +: 8]), 64'(wpix(8 * k + j, row)));
          wbeats++;
        end else begin
          for (int j = 0; j < 8; j++) bus_rdata[8*j +: 8] = mb(a + 32'(j));
        end
      end
      case (ack_mode)
        0: bus_ack = 1'b0;
        1: bus_ack = 1'b1;
        default: bus_ack = ($urandom % 4) != 0;
      endcase
      if (bus_req && bus_ack) begin
        q_due.push_back(ncyc + LAT); q_addr.push_back(bus_addr); q_we.push_back(bus_we);
        if (acc_n < 8) acc_log[acc_n] = bus_addr;
        acc_n++;
        if (!bus_we) nrd++;
      end
      for (int s = 0; s < NUM_RD; s++) begin
        rd_ready[s] = (rdy_mode != 0) && (($urandom % 3) != 0);
        if (rd_valid[s] && rd_ready[s]) begin
          chk("R3 read pixel", 64'(rd_data[8*s +: 8]), 64'(mb(rb[s] + 32'(rcnt[s]))));
          rcnt[s]++;
        end
      end
      if (wr_mode != 0 && wcnt < WTOT && (wr_mode == 2 || ($urandom % 3) != 0)) begin
        wr_valid = 1'b1;
        wr_data  = wpix(wcnt, row);
        wr_last  = (wcnt == WTOT - 1);
        if (wr_ready) wcnt++;
      end else begin
        wr_valid = 1'b0;
        wr_last  = 1'b0;
      end
    end
  end

  task automatic start_row(input logic [31:0] b0, input logic [31:0] b1, input logic [31:0] bo);
    @(posedge clk); #1;
    rb[0] = b0; rb[1] = b1;
    rd_base = {b1, b0}; out_base = bo;
    rcnt[0] = 0; rcnt[1] = 0; wcnt = 0; wbeats = 0; nrd = 0; acc_n = 0;
    row_start = 1'b1;
    @(posedge clk); #1;
    row_start = 1'b0;
  endtask

  task automatic wait_row();
    while (!(rcnt[0] == RPIX && rcnt[1] == RPIX && wcnt == WTOT && wbeats == 8)) @(posedge clk);
    repeat (4) @(posedge clk);
    chk("R4 read beats per row", 64'(nrd), 64'(2 * TILES));
    chk("R6 write beats per row", 64'(wbeats), 64'd8);
    chk("R3 stream 0 pixels consumed", 64'(rcnt[0]), 64'(RPIX));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 bus_req in reset", 64'(bus_req), 64'd0);
    chk("R1 rd_valid in reset", 64'(rd_valid), 64'd0);
    chk("R1 wr_ready in reset", 64'(wr_ready), 64'd1);
    chk("R1 bus_wvalid in reset", 64'(bus_wvalid), 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    ack_mode = 1;
    repeat (6) @(posedge clk);
    chk("R4 no read before row_start", 64'(acc_n), 64'd0);

    // row 1: all read streams ask at once, bus wide open, core stalled
    row = 1;
    start_row(32'h1000, 32'h2000, 32'h3000);
    repeat (20) @(posedge clk);
    chk("R4 two beats per stream while stalled", 64'(acc_n), 64'd4);
    chk("R5 grant order 0", 64'(acc_log[0]), 64'h1000);
    chk("R5 grant order 1", 64'(acc_log[1]), 64'h2000);
    chk("R5 grant order 2", 64'(acc_log[2]), 64'h1008);
    chk("R5 grant order 3", 64'(acc_log[3]), 64'h2008);
    @(posedge clk); #1;
    ack_mode = 2; rdy_mode = 1; wr_mode = 1;
    wait_row();

    // row 2: bus stalled while the core keeps pushing results
    @(posedge clk); #1;
    ack_mode = 0; wr_mode = 2;
    row = 2;
    start_row(32'h4000, 32'h5000, 32'h6000);
    repeat (40) @(negedge clk);
    chk("R9 pushes held after two closed banks", 64'(wcnt), 64'd16);
    chk("R9 wr_ready low", 64'(wr_ready), 64'd0);
    chk("R8 no write data phase while stalled", 64'(bus_wvalid), 64'd0);
    chk("R3 no read data without bus", 64'(rd_valid), 64'd0);
    @(posedge clk); #1;
    ack_mode = 2; wr_mode = 1;
    wait_row();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired R4 actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule